// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a sliced, active-low composite sync stream and a line-rate horizontal pulse. Both are already sampled on the system clock. From these it builds an active-low vertical sync output and an odd/even field flag. Broad vertical-interval pulses are recognised by a saturating integrator. It counts up by one for each cycle the sync input is low and drops by a programmable step for each cycle it is high. A sync pulse is called broad when the integrator reaches the threshold while that pulse is low.

The vertical output begins on the rising sync edge that ends a broad pulse. It ends on the rising edge of the second non-broad pulse that follows, so its width is fixed by the sync pattern and not by a timer. Some signals carry one long vertical pulse with no serrations. For these, a fallback timer starts the output a fixed number of cycles after that pulse began. The field parity comes from the line phase, measured from the last horizontal pulse rising edge and taken at the falling edge of the broad pulse that opens the interval. It is copied to the field flag on the cycle the vertical output goes low. All thresholds and timeouts are parameters counted in clock cycles.

Top module: `vert_field_detector`

## Requirements
- R1: While reset is held and on the first cycle after it, `vsync_n` reads 1 and `field_odd` reads 0 (even).
- R2: Start with the integrator at zero. A sync low run of at least THRESH cycles is a broad pulse, and a shorter run is not. The integrator never exceeds INTEG_MAX.
- R3: When the sync input reads high after a broad pulse while `vsync_n` is high, `vsync_n` goes low on that clock edge. The change is visible from the following cycle.
- R4: Once `vsync_n` is low, it returns high at the rising edge of the second non-broad pulse in a row. A broad pulse in between restarts the count. With standard timing the width is 7 half-lines plus the equalizing low time minus the broad low time.
- R5: Suppose the sync input stays low for FALLBACK_CYC cycles after its falling edge while `vsync_n` is high. Then `vsync_n` goes low on the clock edge FALLBACK_CYC cycles after the edge that saw the sync fall. The end follows R4.
- R6: The line phase is the number of cycles since the last rising edge of `hpulse`, and it is captured at each sync falling edge. When `vsync_n` goes low, `field_odd` becomes 1 if the captured phase is below HALF_LINE/2 or at least 3*HALF_LINE/2. Otherwise it becomes 0.
- R7: `field_odd` changes only on the cycle `vsync_n` goes low, and it holds its value between vertical intervals.
- R8: Short glitches during normal lines, and extra short pulses among the pre-equalizing pulses, neither start the vertical output nor alter the field decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csync_n | input | 1 | Sliced composite sync, low during sync |
| hpulse | input | 1 | Regenerated horizontal pulse, high at line start |
| vsync_n | output | 1 | Vertical sync, low during the vertical interval |
| field_odd | output | 1 | 1 for odd field, 0 for even field |

## Verification
The fallback start is the hardest situation to reach, because only a vertical interval with no serrations can expose it. Any rising edge before the timeout would take the normal path instead. The stimulus merges the first five broad half-lines into one unbroken low run, so the timer expires mid-pulse. The bench then checks that the output still ends on the second post-equalizing edge. It does this for both field parities, which places the captured phase near each side of the decision window. A length sweep of isolated low pulses across the threshold pins the integrator boundary exactly.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        V_IDLE   = 2'd0,
        V_ACTIVE = 2'd1,
        V_TAIL   = 2'd2
    } vphase_e;

    typedef struct packed {
        logic    sync;
        logic    hit;
        vphase_e ph;
        logic    vsync_n;
        logic    field_odd;
    } vsd_state_t;

endpackage

// File: rtl/vsd_integrator.sv
module vsd_integrator #(
    parameter int INTEG_MAX  = 1200,
    parameter int THRESH     = 600,
    parameter int DECAY_STEP = 6,
    localparam int IW        = $clog2(INTEG_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csync_n,
    output logic          at_thresh,
    output logic [IW-1:0] level
);
    localparam logic [IW-1:0] LIM  = IW'(INTEG_MAX);
    localparam logic [IW-1:0] STEP = IW'(DECAY_STEP);
    localparam logic [IW-1:0] TH   = IW'(THRESH);

    logic [IW-1:0] level_d, level_q;

    always_comb begin
        if (!csync_n) begin
            level_d = (level_q >= LIM) ? LIM : level_q + IW'(1);
        end else begin
            level_d = (level_q > STEP) ? level_q - STEP : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign at_thresh = (level_q >= TH);
    assign level     = level_q;

endmodule

// File: rtl/vsd_fallback_timer.sv
module vsd_fallback_timer #(
    parameter int FALLBACK_CYC = 3250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic expired
);
    localparam int FW = $clog2(FALLBACK_CYC + 1);
    localparam logic [FW-1:0] LIM = FW'(FALLBACK_CYC);

    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (csync_n)          cnt_d = '0;
        else if (cnt_q == LIM) cnt_d = LIM;
        else                  cnt_d = cnt_q + FW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM);

endmodule

// File: rtl/vsd_line_phase.sv
module vsd_line_phase #(
    parameter int HALF_LINE = 1588
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hpulse,
    input  logic capture,
    output logic odd_phase
);
    localparam int LMAX  = 4 * HALF_LINE;
    localparam int LW    = $clog2(LMAX + 1);
    localparam int QTR   = HALF_LINE / 2;
    localparam int UPPER = HALF_LINE + QTR;

    logic          hp_d, hp_q;
    logic [LW-1:0] cnt_d, cnt_q;
    logic [LW-1:0] cap_d, cap_q;

    always_comb begin
        hp_d = hpulse;
        if (hpulse && !hp_q)          cnt_d = '0;
        else if (cnt_q == LW'(LMAX))  cnt_d = cnt_q;
        else                          cnt_d = cnt_q + LW'(1);
        cap_d = capture ? cnt_q : cap_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_q  <= 1'b0;
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            hp_q  <= hp_d;
            cnt_q <= cnt_d;
            cap_q <= cap_d;
        end
    end

    assign odd_phase = (cap_q < LW'(QTR)) || (cap_q >= LW'(UPPER));

endmodule

// File: rtl/vert_field_detector.sv
module vert_field_detector #(
    parameter int THRESH       = 600,
    parameter int INTEG_MAX    = 1200,
    parameter int DECAY_STEP   = 6,
    parameter int FALLBACK_CYC = 3250,
    parameter int HALF_LINE    = 1588
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    input  logic hpulse,
    output logic vsync_n,
    output logic field_odd
);
    import vsd_pkg::*;

    localparam int IW = $clog2(INTEG_MAX + 1);

    vsd_state_t    s_d, s_q;
    logic [IW-1:0] integ_level;
    logic          at_thresh;
    logic          fb_expired;
    logic          odd_phase;
    logic          sync_rise;
    logic          sync_fall;
    logic          broad_pulse;

    assign sync_rise = !s_q.sync && csync_n;
    assign sync_fall = s_q.sync && !csync_n;

    vsd_integrator #(
        .INTEG_MAX (INTEG_MAX),
        .THRESH    (THRESH),
        .DECAY_STEP(DECAY_STEP)
    ) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .csync_n  (csync_n),
        .at_thresh(at_thresh),
        .level    (integ_level)
    );

    vsd_fallback_timer #(
        .FALLBACK_CYC(FALLBACK_CYC)
    ) u_fallback (
        .clk    (clk),
        .rst_n  (rst_n),
        .csync_n(csync_n),
        .expired(fb_expired)
    );

    vsd_line_phase #(
        .HALF_LINE(HALF_LINE)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .hpulse   (hpulse),
        .capture  (sync_fall),
        .odd_phase(odd_phase)
    );

    always_comb begin
        s_d         = s_q;
        s_d.sync    = csync_n;
        broad_pulse = s_q.hit | at_thresh;
        s_d.hit     = sync_fall ? 1'b0 : broad_pulse;
        case (s_q.ph)
            V_IDLE: begin
                if ((sync_rise && broad_pulse) || (!csync_n && fb_expired)) begin
                    s_d.ph        = V_ACTIVE;
                    s_d.vsync_n   = 1'b0;
                    s_d.field_odd = odd_phase;
                end
            end
            V_ACTIVE: begin
                if (sync_rise && !broad_pulse) s_d.ph = V_TAIL;
            end
            V_TAIL: begin
                if (sync_rise) begin
                    if (broad_pulse) begin
                        s_d.ph = V_ACTIVE;
                    end else begin
                        s_d.ph      = V_IDLE;
                        s_d.vsync_n = 1'b1;
                    end
                end
            end
            default: s_d.ph = V_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sync      <= 1'b1;
            s_q.hit       <= 1'b0;
            s_q.ph        <= V_IDLE;
            s_q.vsync_n   <= 1'b1;
            s_q.field_odd <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vsync_n   = s_q.vsync_n;
    assign field_odd = s_q.field_odd;

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
    parameter int INTEG_MAX = 1200,
    localparam int IW       = $clog2(INTEG_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          csync_n,
    input logic          vsync_n,
    input logic          field_odd,
    input logic [IW-1:0] level
);

    // R3 R5
    vsync_start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> (($past(csync_n) && !$past(csync_n, 2)) || !$past(csync_n)));

    // R4
    vsync_end_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_n) |-> ($past(csync_n) && !$past(csync_n, 2)));

    // R7
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> $fell(vsync_n));

    // R2
    integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= IW'(INTEG_MAX));

    // R8
    no_start_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csync_n) && $past(csync_n, 2)) |-> !$fell(vsync_n));

endmodule

bind vert_field_detector vsd_checker #(.INTEG_MAX(INTEG_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csync_n  (csync_n),
    .vsync_n  (vsync_n),
    .field_odd(field_odd),
    .level    (integ_level)
);

// File: tb/vert_field_detector_tb.sv
module vert_field_detector_tb;

    localparam int TH   = 12;
    localparam int IMAX = 24;
    localparam int DEC  = 8;
    localparam int FB   = 66;
    localparam int HALF = 32;
    localparam int BROAD_LOW = 28;
    localparam int EQ_LOW    = 2;
    localparam int END_OFS   = 7 * HALF + EQ_LOW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n = 1'b1;
    logic hpulse = 1'b0;
    logic vsync_n;
    logic field_odd;

    int checks = 0;
    int bad = 0;
    int idx = 0;
    int fall_cnt = 0;
    int rise_cnt = 0;
    int fall_idx = -1;
    int rise_idx = -1;
    logic prev_vs = 1'b1;
    bit done = 0;

    always #10ns clk = ~clk;

    vert_field_detector #(
        .THRESH(TH), .INTEG_MAX(IMAX), .DECAY_STEP(DEC),
        .FALLBACK_CYC(FB), .HALF_LINE(HALF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .hpulse(hpulse),
        .vsync_n(vsync_n), .field_odd(field_odd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // observe outputs (result of the edge for sample idx-1), then drive sample idx
    task automatic step(input logic c, input logic h);
        @(negedge clk);
        if (prev_vs && !vsync_n) begin fall_cnt++; fall_idx = idx - 1; end
        if (!prev_vs && vsync_n) begin rise_cnt++; rise_idx = idx - 1; end
        prev_vs = vsync_n;
        csync_n = c;
        hpulse  = h;
        idx++;
    endtask

    task automatic half(input int low, input bit hfirst, input int glitch);
        for (int i = 0; i < HALF; i++) begin
            step(!((i < low) || (glitch > 0 && i >= glitch && i < glitch + 2)),
                 hfirst && (i < 3));
        end
    endtask

    task automatic normal_lines(input int n, input int glitch);
        for (int k = 0; k < n; k++) begin
            half(5, 1'b1, glitch);
            half(0, 1'b0, 0);
        end
    endtask

    task automatic vert(input bit odd_f, input bit serr, input int pglitch, output int t0);
        bit hf;
        hf = 1'b1;
        if (!odd_f) begin
            half(5, 1'b1, 0);
            hf = 1'b0;
        end
        for (int k = 0; k < 6; k++) begin
            half(EQ_LOW, hf, (k == 2) ? pglitch : 0);
            hf = !hf;
        end
        t0 = idx;
        for (int k = 0; k < 6; k++) begin
            half((serr || k == 5) ? BROAD_LOW : HALF, hf, 0);
            hf = !hf;
        end
        for (int k = 0; k < 6; k++) begin
            half(EQ_LOW, hf, 0);
            hf = !hf;
        end
        if (!odd_f) half(0, 1'b0, 0);
    endtask

    task automatic run_field(input bit odd_f, input bit serr, input int pglitch, input string tag);
        int t0;
        int exp_start;
        fall_cnt = 0;
        rise_cnt = 0;
        normal_lines(3, 0);
        vert(odd_f, serr, pglitch, t0);
        normal_lines(2, 0);
        exp_start = t0 + (serr ? BROAD_LOW : FB);
        chk(fall_cnt == 1, {tag, " R3 one vertical start"}, fall_cnt, 1);
        if (serr) chk(fall_idx == exp_start, {tag, " R3 start on serration edge"}, fall_idx - t0, BROAD_LOW);
        else      chk(fall_idx == exp_start, {tag, " R5 fallback start"}, fall_idx - t0, FB);
        chk(rise_idx == t0 + END_OFS, {tag, " R4 end on second post-eq edge"}, rise_idx - t0, END_OFS);
        chk(rise_idx - fall_idx == END_OFS - (serr ? BROAD_LOW : FB), {tag, " R4 width"},
            rise_idx - fall_idx, END_OFS - (serr ? BROAD_LOW : FB));
        chk(field_odd == odd_f, {tag, " R6 field parity"}, field_odd, odd_f);
        chk(vsync_n == 1'b1, {tag, " R4 idle after interval"}, vsync_n, 1);
    endtask

    initial begin
        int t0;
        int t1;
        repeat (4) @(negedge clk);
        chk(vsync_n == 1'b1, "R1 vsync in reset", vsync_n, 1);
        chk(field_odd == 1'b0, "R1 field in reset", field_odd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vsync_n == 1'b1, "R1 vsync after reset", vsync_n, 1);
        chk(field_odd == 1'b0, "R1 field after reset", field_odd, 0);

        // normal video with impulse glitches: nothing happens
        fall_cnt = 0;
        normal_lines(6, 20);
        chk(fall_cnt == 0, "R8 glitches in lines", fall_cnt, 0);
        chk(field_odd == 1'b0, "R8 field untouched by glitches", field_odd, 0);

        run_field(1'b1, 1'b1, 0, "odd/serrated");
        // field holds across ordinary lines
        fall_cnt = 0;
        normal_lines(4, 20);
        chk(field_odd == 1'b1, "R7 field holds between intervals", field_odd, 1);
        chk(fall_cnt == 0, "R8 no start in lines", fall_cnt, 0);
        run_field(1'b0, 1'b1, 0, "even/serrated");
        run_field(1'b1, 1'b1, 14, "odd/extra pre-eq R8");
        run_field(1'b0, 1'b1, 14, "even/extra pre-eq R8");
        run_field(1'b1, 1'b0, 0, "odd/no serration");
        run_field(1'b0, 1'b0, 0, "even/no serration");

        // R2 sweep of isolated low pulse lengths across the threshold
        for (int len = 1; len <= 2 * TH; len++) begin
            fall_cnt = 0;
            rise_cnt = 0;
            repeat (40) step(1'b1, 1'b0);
            t0 = idx;
            repeat (len) step(1'b0, 1'b0);
            repeat (40) step(1'b1, 1'b0);
            if (len >= TH) begin
                chk(fall_cnt == 1 && fall_idx == t0 + len, $sformatf("R2 len=%0d starts", len),
                    fall_idx - t0, len);
            end else begin
                chk(fall_cnt == 0, $sformatf("R2 len=%0d ignored", len), fall_cnt, 0);
            end
            repeat (EQ_LOW) step(1'b0, 1'b0);
            repeat (30) step(1'b1, 1'b0);
            t1 = idx;
            repeat (EQ_LOW) step(1'b0, 1'b0);
            repeat (30) step(1'b1, 1'b0);
            if (len >= TH)
                chk(rise_cnt == 1 && rise_idx == t1 + EQ_LOW, $sformatf("R4 len=%0d end", len),
                    rise_idx - t1, EQ_LOW);
            chk(vsync_n == 1'b1, $sformatf("R4 len=%0d idle", len), vsync_n, 1);
        end

        // R4 broad pulse between post pulses restarts the count
        fall_cnt = 0;
        rise_cnt = 0;
        repeat (40) step(1'b1, 1'b0);
        repeat (20) step(1'b0, 1'b0);
        repeat (40) step(1'b1, 1'b0);
        repeat (EQ_LOW) step(1'b0, 1'b0);
        repeat (30) step(1'b1, 1'b0);
        repeat (20) step(1'b0, 1'b0);
        repeat (40) step(1'b1, 1'b0);
        repeat (EQ_LOW) step(1'b0, 1'b0);
        repeat (30) step(1'b1, 1'b0);
        chk(rise_cnt == 0 && vsync_n == 1'b0, "R4 restart keeps output low", rise_cnt, 0);
        t1 = idx;
        repeat (EQ_LOW) step(1'b0, 1'b0);
        repeat (30) step(1'b1, 1'b0);
        chk(rise_cnt == 1 && rise_idx == t1 + EQ_LOW, "R4 end after restart", rise_idx - t1, EQ_LOW);
        chk(fall_cnt == 1, "R3 single start in restart case", fall_cnt, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule